// File: doc/BRIEF.md
# Single-Dword PCI Target Sequencer

This block is the bus-side sequencer of a 32-bit PCI target that handles one dword per transaction. An address decoder outside the block watches the address phase and reports either a configuration hit or one of several memory BAR hits. The sequencer claims the cycle when either kind of hit is present. It captures the address and command, asserts DEVSEL# with medium timing, and runs the IRDY#/TRDY# handshake for the single data phase. It then drives the target controls high for one turnaround clock and releases them. Each bus signal is modelled as a value paired with an output enable, so no tristate nets are used.

A master may hold FRAME# low for only the address clock. The sequencer does not fall back to idle when FRAME# rises. It stays in the data phase until the handshake completes or until a wait limit expires. On that limit it signals a target abort. On the back end, a read strobe asks for data one clock before the data phase begins. A write strobe carries the data and byte enables on the clock after the handshake completes.

Top module: `pci_tgt_seq`

## Requirements
- R1: A cycle is claimed only when FRAME# is sampled low and the configuration hit or any BAR hit is high on that same clock. Without a hit, DEVSEL#, TRDY# and STOP# are never driven. `be_cfg` and `be_bar` report which hit claimed the cycle.
- R2: The address and the command are captured on the claiming clock. `be_addr` keeps the captured address after AD changes to data.
- R3: DEVSEL# uses medium timing. In the clock after the address phase it is not driven. In the second clock it is driven low. `devsel_timing` reads 2'b01.
- R4: After a FRAME# that lasts one clock, the block stays in the data phase with DEVSEL# and TRDY# low for as long as IRDY# stays high.
- R5: A data phase completes on a clock where IRDY# and TRDY# are both sampled low. In the next clock DEVSEL# and TRDY# are driven high. One clock after that, all enables are off.
- R6: Command bit 0 set (C/BE#[0] high in the address phase) marks a write. On the clock after completion, `be_wr` is high for exactly one clock. With it, `be_wdata` carries the AD value and `be_byte_en` carries the inverted C/BE# value, both sampled at completion.
- R7: A read (command bit 0 clear) raises `be_rd` in the clock after the address phase. In the data phase AD is driven with the `be_rdata` value present during the `be_rd` clock. AD is released when the data phase ends.
- R8: When IRDY# stays high for WAIT_LIMIT data-phase clocks, the block gives one abort clock with STOP# low and DEVSEL# and TRDY# high. It then gives one turnaround clock and returns to idle, and it never raises `be_wr`. A handshake on the last allowed clock completes the transfer normally.
- R9: While `rst_n` is low at a clock edge, the block returns to idle and all output enables go low on the next clock.
- R10: A FRAME# low that continues a transaction already in progress (FRAME# or IRDY# low on the previous clock) is never claimed, even if a hit is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | FRAME# as sampled from the bus |
| irdy_n | input | 1 | IRDY# as sampled from the bus |
| ad_in | input | 32 | AD as sampled from the bus |
| cbe_n | input | 4 | C/BE# as sampled from the bus |
| cfg_hit | input | 1 | Decoder: configuration cycle aimed at this device |
| bar_hit | input | NBAR | Decoder: memory address inside BAR n |
| ad_out | output | 32 | AD value driven during a read data phase |
| ad_oe | output | 1 | AD output enable |
| devsel_n_o | output | 1 | DEVSEL# drive value |
| devsel_oe | output | 1 | DEVSEL# output enable |
| trdy_n_o | output | 1 | TRDY# drive value |
| trdy_oe | output | 1 | TRDY# output enable |
| stop_n_o | output | 1 | STOP# drive value |
| stop_oe | output | 1 | STOP# output enable |
| devsel_timing | output | 2 | DEVSEL timing code for the status register (01 = medium) |
| be_addr | output | 32 | Captured address |
| be_cfg | output | 1 | Claimed by the configuration hit |
| be_bar | output | NBAR | BAR hits captured at claim |
| be_rd | output | 1 | Read request, one clock |
| be_rdata | input | 32 | Back-end read data for `be_addr` |
| be_wr | output | 1 | Write strobe, one clock |
| be_wdata | output | 32 | Write data |
| be_byte_en | output | 4 | Write byte enables, active high |

## Verification
The wait-limit abort and the normal completion can fall on the same clock. This happens when the master asserts IRDY# on exactly the last data-phase clock the limit allows. The bench provokes it by holding IRDY# high for WAIT_LIMIT-1 data clocks and then lowering it for the final one. On the following clock the bench requires a turnaround with STOP# high and a write strobe, not an abort. A separate scenario that never asserts IRDY# confirms that the abort appears exactly one clock later.

// File: rtl/pci_tgt_seq.sv
module pci_tgt_seq #(
  parameter int NBAR       = 2,
  parameter int WAIT_LIMIT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic [31:0]     ad_in,
  input  logic [3:0]      cbe_n,
  input  logic            cfg_hit,
  input  logic [NBAR-1:0] bar_hit,
  output logic [31:0]     ad_out,
  output logic            ad_oe,
  output logic            devsel_n_o,
  output logic            devsel_oe,
  output logic            trdy_n_o,
  output logic            trdy_oe,
  output logic            stop_n_o,
  output logic            stop_oe,
  output logic [1:0]      devsel_timing,
  output logic [31:0]     be_addr,
  output logic            be_cfg,
  output logic [NBAR-1:0] be_bar,
  output logic            be_rd,
  input  logic [31:0]     be_rdata,
  output logic            be_wr,
  output logic [31:0]     be_wdata,
  output logic [3:0]      be_byte_en
);

  localparam int CW = $clog2(WAIT_LIMIT) + 1;
  localparam logic [CW-1:0] LAST_WAIT = CW'(WAIT_LIMIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_BUSY, S_DATA, S_ABORT, S_TURN} st_t;

  st_t             state, state_nx;
  logic            bus_idle_q, write_q, cfg_q, wr_q;
  logic [31:0]     addr_q, rdata_q, wdata_q;
  logic [3:0]      ben_q;
  logic [NBAR-1:0] bar_q;
  logic [CW-1:0]   wait_q;
  logic            in_idle, any_hit, claim, hs, timeout, driving;

  assign any_hit = cfg_hit | (|bar_hit);
  assign in_idle = (state == S_IDLE);
  assign claim   = in_idle & ~frame_n & bus_idle_q & any_hit;
  assign hs      = (state == S_DATA) & ~irdy_n;
  assign timeout = (state == S_DATA) & irdy_n & (wait_q == LAST_WAIT);

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:  if (claim) state_nx = S_BUSY;
      S_BUSY:  state_nx = S_DATA;
      S_DATA:  if (hs) state_nx = S_TURN;
               else if (timeout) state_nx = S_ABORT;
      S_ABORT: state_nx = S_TURN;
      S_TURN:  state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      bus_idle_q <= 1'b1;
      write_q    <= 1'b0;
      cfg_q      <= 1'b0;
      bar_q      <= '0;
      addr_q     <= '0;
      rdata_q    <= '0;
      wdata_q    <= '0;
      ben_q      <= '0;
      wait_q     <= '0;
      wr_q       <= 1'b0;
    end else begin
      state      <= state_nx;
      bus_idle_q <= frame_n & irdy_n;
      wr_q       <= hs & write_q;
      if (claim) begin
        addr_q  <= ad_in;
        write_q <= cbe_n[0];
        cfg_q   <= cfg_hit;
        bar_q   <= bar_hit;
      end
      if (state == S_BUSY) begin
        rdata_q <= be_rdata;
        wait_q  <= '0;
      end else if (state == S_DATA && irdy_n) begin
        wait_q <= wait_q + 1'b1;
      end
      if (hs) begin
        wdata_q <= ad_in;
        ben_q   <= ~cbe_n;
      end
    end
  end

  assign driving       = (state == S_DATA) | (state == S_ABORT) | (state == S_TURN);
  assign devsel_oe     = driving;
  assign trdy_oe       = driving;
  assign stop_oe       = driving;
  assign devsel_n_o    = (state != S_DATA);
  assign trdy_n_o      = (state != S_DATA);
  assign stop_n_o      = (state != S_ABORT);
  assign ad_oe         = (state == S_DATA) & ~write_q;
  assign ad_out        = rdata_q;
  assign devsel_timing = 2'b01;
  assign be_addr       = addr_q;
  assign be_cfg        = cfg_q;
  assign be_bar        = bar_q;
  assign be_rd         = (state == S_BUSY) & ~write_q;
  assign be_wr         = wr_q;
  assign be_wdata      = wdata_q;
  assign be_byte_en    = ben_q;

endmodule

// File: rtl/pci_tgt_seq_chk.sv
module pci_tgt_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_n,
  input logic irdy_n,
  input logic in_idle,
  input logic any_hit,
  input logic devsel_n_o,
  input logic devsel_oe,
  input logic trdy_n_o,
  input logic trdy_oe,
  input logic stop_n_o,
  input logic stop_oe,
  input logic be_rd,
  input logic be_wr
);

  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !devsel_oe && !trdy_oe && !stop_oe);

  a_r1_no_hit_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !frame_n && !any_hit) |=> in_idle);

  a_r3_medium_devsel: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(devsel_oe) && !devsel_n_o) |-> !$past(frame_n, 2));

  a_r7_rd_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    be_rd |=> devsel_oe && !devsel_n_o && !trdy_n_o);

  a_r4_hold_until_irdy: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_oe && !trdy_n_o && irdy_n) |=> (!trdy_n_o || !stop_n_o));

  a_r5_done_turns_high: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_oe && !trdy_n_o && !irdy_n) |=> devsel_oe && devsel_n_o && trdy_n_o && stop_n_o);

  a_r5_release_after_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (devsel_oe && devsel_n_o && stop_n_o) |=> !devsel_oe && !trdy_oe && !stop_oe);

  a_r8_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_oe && !stop_n_o) |-> !be_wr && devsel_n_o && trdy_n_o);

  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    be_wr |=> !be_wr);

endmodule

bind pci_tgt_seq pci_tgt_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n    (frame_n),
  .irdy_n     (irdy_n),
  .in_idle    (in_idle),
  .any_hit    (any_hit),
  .devsel_n_o (devsel_n_o),
  .devsel_oe  (devsel_oe),
  .trdy_n_o   (trdy_n_o),
  .trdy_oe    (trdy_oe),
  .stop_n_o   (stop_n_o),
  .stop_oe    (stop_oe),
  .be_rd      (be_rd),
  .be_wr      (be_wr)
);

// File: tb/test_pci_tgt_seq.sv
`timescale 1ns/1ps
module test_pci_tgt_seq;
  localparam int NBAR = 2;
  localparam int WL   = 8;
  localparam logic [31:0] RMASK = 32'h5A5A_0F0F;

  logic            clk = 1'b0;
  logic            rst_n, frame_n, irdy_n, cfg_hit;
  logic [31:0]     ad_in;
  logic [3:0]      cbe_n;
  logic [NBAR-1:0] bar_hit;
  logic [31:0]     ad_out, be_addr, be_rdata, be_wdata;
  logic            ad_oe, devsel_n_o, devsel_oe, trdy_n_o, trdy_oe, stop_n_o, stop_oe;
  logic [1:0]      devsel_timing;
  logic            be_cfg, be_rd, be_wr;
  logic [NBAR-1:0] be_bar;
  logic [3:0]      be_byte_en;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;
  assign be_rdata = be_addr ^ RMASK;

  pci_tgt_seq #(.NBAR(NBAR), .WAIT_LIMIT(WL)) i_pci_tgt_seq (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad_in(ad_in),
    .cbe_n(cbe_n), .cfg_hit(cfg_hit), .bar_hit(bar_hit), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n_o(devsel_n_o), .devsel_oe(devsel_oe), .trdy_n_o(trdy_n_o), .trdy_oe(trdy_oe),
    .stop_n_o(stop_n_o), .stop_oe(stop_oe), .devsel_timing(devsel_timing),
    .be_addr(be_addr), .be_cfg(be_cfg), .be_bar(be_bar), .be_rd(be_rd),
    .be_rdata(be_rdata), .be_wr(be_wr), .be_wdata(be_wdata), .be_byte_en(be_byte_en));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_idle();
    frame_n = 1'b1; irdy_n = 1'b1; cfg_hit = 1'b0; bar_hit = '0;
    ad_in = '0; cbe_n = 4'hF;
    @(negedge clk);
  endtask

  // drive address phase at current negedge, return at next negedge
  task automatic addr_phase(input logic [31:0] a, input logic [3:0] cmd,
                            input logic cfg, input logic [NBAR-1:0] bars);
    frame_n = 1'b0; ad_in = a; cbe_n = cmd; cfg_hit = cfg; bar_hit = bars;
    @(negedge clk);
    cfg_hit = 1'b0; bar_hit = '0;
  endtask

  function automatic logic quiet();
    return !devsel_oe && !trdy_oe && !stop_oe && !ad_oe;
  endfunction

  task automatic t_reset();
    chk(quiet(), "R9 outputs off after reset", {devsel_oe, trdy_oe, stop_oe, ad_oe}, 0);
    chk(devsel_timing == 2'b01, "R3 timing code", devsel_timing, 1);
  endtask

  task automatic t_cfg_write();
    bus_idle();
    addr_phase(32'h0000_0010, 4'hB, 1'b1, '0);
    chk(!devsel_oe, "R3 no devsel in first clock", devsel_oe, 0);
    chk(!be_rd, "R6 write gives no read strobe", be_rd, 0);
    frame_n = 1'b1; irdy_n = 1'b0; ad_in = 32'hFFFF_FFFF; cbe_n = 4'h0;
    @(negedge clk);
    chk(devsel_oe && !devsel_n_o, "R3 devsel low in second clock", devsel_n_o, 0);
    chk(!trdy_n_o, "R4 trdy in data phase", trdy_n_o, 0);
    chk(be_addr == 32'h10, "R2 address held", be_addr, 32'h10);
    chk(be_cfg && be_bar == 0, "R1 config claim source", {be_cfg, be_bar}, 32'h4);
    @(negedge clk);
    irdy_n = 1'b1;
    chk(devsel_oe && devsel_n_o && trdy_n_o, "R5 turnaround high", {devsel_n_o, trdy_n_o}, 3);
    chk(be_wr && be_wdata == 32'hFFFF_FFFF && be_byte_en == 4'hF, "R6 write strobe",
        {be_wr, be_byte_en, be_wdata[7:0]}, 32'h1FFF);
    @(negedge clk);
    chk(quiet(), "R5 released after turnaround", {devsel_oe, trdy_oe, stop_oe}, 0);
    chk(!be_wr, "R6 strobe one clock", be_wr, 0);
  endtask

  task automatic t_bar_read();
    bus_idle();
    addr_phase(32'h1000_0040, 4'h6, 1'b0, 2'b10);
    chk(be_rd, "R7 read strobe", be_rd, 1);
    frame_n = 1'b1; irdy_n = 1'b0; ad_in = 32'h0; cbe_n = 4'h0;
    @(negedge clk);
    chk(ad_oe && ad_out == (32'h1000_0040 ^ RMASK), "R7 read data driven", ad_out,
        32'h1000_0040 ^ RMASK);
    chk(!be_cfg && be_bar == 2'b10, "R1 BAR claim source", {be_cfg, be_bar}, 2);
    @(negedge clk);
    irdy_n = 1'b1;
    chk(!ad_oe && !be_wr, "R7 AD released, no write", {ad_oe, be_wr}, 0);
    @(negedge clk);
    chk(quiet(), "R5 idle after read", {devsel_oe, trdy_oe}, 0);
  endtask

  task automatic t_wait();
    bus_idle();
    addr_phase(32'h2000_0000, 4'h7, 1'b0, 2'b01);
    frame_n = 1'b1; irdy_n = 1'b1; ad_in = 32'h1234_5678; cbe_n = 4'h5;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(devsel_oe && !devsel_n_o && !trdy_n_o && !be_wr, "R4 hold while IRDY# high",
          {devsel_n_o, trdy_n_o, be_wr}, 0);
    end
    irdy_n = 1'b0;
    @(negedge clk);
    irdy_n = 1'b1;
    chk(be_wr && be_wdata == 32'h1234_5678 && be_byte_en == 4'hA, "R6 write after wait",
        be_wdata, 32'h1234_5678);
    @(negedge clk);
  endtask

  task automatic t_no_hit();
    bus_idle();
    addr_phase(32'h3000_0000, 4'h7, 1'b0, '0);
    frame_n = 1'b1; irdy_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(quiet(), "R1 no hit no drive", devsel_oe, 0);
      @(negedge clk);
    end
    irdy_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_midtx();
    bus_idle();
    addr_phase(32'h4000_0000, 4'h7, 1'b0, '0);
    cfg_hit = 1'b1;
    @(negedge clk);
    cfg_hit = 1'b0; frame_n = 1'b1; irdy_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(quiet(), "R10 no claim mid transaction", devsel_oe, 0);
    end
    irdy_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_abort(input bit late_irdy);
    bus_idle();
    addr_phase(32'h5000_0000, 4'h7, 1'b0, 2'b01);
    frame_n = 1'b1; irdy_n = 1'b1; ad_in = 32'hCAFE_0001; cbe_n = 4'h0;
    for (int i = 0; i < WL; i++) begin
      @(negedge clk);
      chk(!trdy_n_o && stop_n_o, "R8 data phase before limit", {trdy_n_o, stop_n_o}, 1);
      if (late_irdy && i == WL - 1) irdy_n = 1'b0;
    end
    @(negedge clk);
    irdy_n = 1'b1;
    if (late_irdy) begin
      chk(stop_n_o && devsel_oe && devsel_n_o && be_wr, "R8 handshake wins on last clock",
          {stop_n_o, be_wr}, 3);
    end else begin
      chk(stop_oe && !stop_n_o && devsel_n_o && trdy_n_o && !be_wr, "R8 abort clock",
          {stop_n_o, devsel_n_o, trdy_n_o, be_wr}, 6);
      @(negedge clk);
      chk(stop_oe && stop_n_o && devsel_n_o && !be_wr, "R8 turnaround after abort",
          {stop_n_o, be_wr}, 2);
    end
    @(negedge clk);
    chk(quiet() && !be_wr, "R8 back to idle", {devsel_oe, be_wr}, 0);
  endtask

  task automatic t_reset_mid();
    bus_idle();
    addr_phase(32'h6000_0000, 4'h7, 1'b0, 2'b01);
    frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(quiet(), "R9 reset mid transaction", {devsel_oe, trdy_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(quiet(), "R9 stays idle after reset", devsel_oe, 0);
  endtask

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; cfg_hit = 1'b0; bar_hit = '0;
    ad_in = '0; cbe_n = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_write();
    t_bar_read();
    t_wait();
    t_no_hit();
    t_midtx();
    t_abort(1'b0);
    t_abort(1'b1);
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule